// File: doc/BRIEF.md
# Triggered Long-Range Timer Counter

This block is a synchronous timer that stretches a slow timebase over a chain of binary divider stages. A start pulse loads every stage to ones, which drives both active-low outputs low. Each falling timebase edge then steps the chain down by one. The fast output is the inverse of the lowest stage, so it toggles on every counted edge. The slow output is the inverse of the top stage. It goes high again after half the chain's range, which is 128 timebase periods with the default eight stages.

A mode pin picks between two behaviours. In free-run mode the chain wraps and the slow output is a square wave of 256 timebase periods. In one-shot mode the moment the slow output would rise acts as an internal clear, so the block returns to idle with both outputs high. Everything runs on one system clock. The timebase, start and clear pins are asynchronous and go through a two-flop synchroniser followed by edge detection. Because the slow output is a clean level, it can be fed into the timebase pin of a further instance to multiply the period.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. All pins are plain control and status levels or single-cycle pulses.

Top module: `longrange_timer`

## Requirements
- R1: After `rst_n` is released, `half_n_o` and `slow_n_o` are 1 and `running_o` and `done_o` are 0.
- R2: When `start_i` is first sampled high at clock edge n after being low, the outputs after edge n+2 are `half_n_o`=0, `slow_n_o`=0 and `running_o`=1.
- R3: While running, each falling `tbase_i` edge sampled at edge n steps the chain after edge n+2, and `half_n_o` inverts. Rising timebase edges and clock cycles without a timebase edge leave both outputs unchanged.
- R4: In free-run mode (`oneshot_i`=0), `slow_n_o` goes high on the 128th counted falling edge after a start and goes low again on the 256th, so its period is 256 timebase periods.
- R5: In one-shot mode (`oneshot_i`=1), the 128th counted falling edge clears the block. After that edge both outputs are 1, `running_o` is 0, and `done_o` is 1 for exactly one clock cycle.
- R6: If `clear_i` is sampled high on two consecutive edges while the synchronised `start_i` is low, the block becomes idle one edge after the synchroniser delay, with both outputs 1. While `start_i` is held high, `clear_i` has no effect.
- R7: If the start edge and a high `clear_i` reach the control logic together, the start wins and the block runs.
- R8: A new start edge while the block is running reloads all stages, so both outputs go low again and the count restarts.
- R9: A falling timebase edge that arrives in the same cycle as a start edge is not counted.
- R10: While idle, timebase edges are ignored and both outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_i | input | 1 | Asynchronous timebase; the chain counts its falling edges |
| start_i | input | 1 | Asynchronous start; its rising edge loads the chain |
| clear_i | input | 1 | Asynchronous level clear; overridden by `start_i` |
| oneshot_i | input | 1 | 1 selects one-shot mode, 0 selects free-run mode |
| half_n_o | output | 1 | Inverted lowest stage (timebase / 2) |
| slow_n_o | output | 1 | Inverted top stage (timebase / 256) |
| running_o | output | 1 | High from a start until the block is cleared |
| done_o | output | 1 | One-cycle pulse when a one-shot interval ends |

## Verification
Any corruption of the stage registers shows up on `half_n_o` within one counted timebase edge, because that output must invert on every step. A wrong upper stage shows up on `slow_n_o` by the 128th step at the latest, as an edge that comes early or late. A control flag that disagrees with the chain is visible straight away, because `running_o` low must always come with both outputs high. A miscounted one-shot end shows as a `done_o` pulse in the wrong cycle or a missing return to idle. The reference model therefore compares all four outputs after every clock edge, so any fault is caught in the cycle it first reaches a pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CHAIN_STAGES = 8;
  localparam int unsigned SYNC_DEPTH   = 2;
  localparam int unsigned N_SYNC       = 3;
  localparam int unsigned IX_TBASE     = 0;
  localparam int unsigned IX_START     = 1;
  localparam int unsigned IX_CLEAR     = 2;

  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_PRESET = 2'd2,
    CMD_STEP   = 2'd3
  } chain_cmd_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  localparam int unsigned TAPS = DEPTH + 1;

  logic [WIDTH-1:0] pipe [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d_i;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[k] <= '0;
      else        pipe[k] <= pipe[k-1];
    end
  end

  assign lvl_o  = pipe[DEPTH-1];
  assign prev_o = pipe[DEPTH];
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = CHAIN_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chain_cmd_e        cmd_i,
  output logic [STAGES-1:0] q_o,
  output logic              at_turn_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] q;
  logic [STAGES:0]   borrow;

  assign borrow[0] = 1'b1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign borrow[s+1] = borrow[s] & ~q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[s] <= 1'b0;
      end else begin
        unique case (cmd_i)
          CMD_PRESET: q[s] <= 1'b1;
          CMD_CLEAR:  q[s] <= 1'b0;
          CMD_STEP:   q[s] <= q[s] ^ borrow[s];
          default:    q[s] <= q[s];
        endcase
      end
    end
  end

  assign q_o       = q;
  assign at_turn_o = q[MSB] & borrow[MSB];
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_rise_i,
  input  logic       ext_clear_i,
  input  logic       tb_fall_i,
  input  logic       oneshot_i,
  input  logic       at_turn_i,
  output chain_cmd_e cmd_o,
  output logic       running_o,
  output logic       done_o
);
  logic run_q, done_q, shot_end;
  chain_cmd_e cmd;

  always_comb begin
    cmd      = CMD_HOLD;
    shot_end = 1'b0;
    if (start_rise_i) begin
      cmd = CMD_PRESET;
    end else if (ext_clear_i) begin
      cmd = CMD_CLEAR;
    end else if (run_q && tb_fall_i) begin
      if (oneshot_i && at_turn_i) begin
        cmd      = CMD_CLEAR;
        shot_end = 1'b1;
      end else begin
        cmd = CMD_STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cmd == CMD_PRESET)     run_q <= 1'b1;
      else if (cmd == CMD_CLEAR) run_q <= 1'b0;
      done_q <= shot_end;
    end
  end

  assign cmd_o     = cmd;
  assign running_o = run_q;
  assign done_o    = done_q;
endmodule

// File: rtl/longrange_timer.sv
module longrange_timer
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = CHAIN_STAGES,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tbase_i,
  input  logic start_i,
  input  logic clear_i,
  input  logic oneshot_i,
  output logic half_n_o,
  output logic slow_n_o,
  output logic running_o,
  output logic done_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [N_SYNC-1:0] raw, lvl, prev;
  logic              start_rise, tb_fall, clear_hold, ext_clear, at_turn;
  logic [STAGES-1:0] q;
  chain_cmd_e        cmd;

  assign raw[IX_TBASE] = tbase_i;
  assign raw[IX_START] = start_i;
  assign raw[IX_CLEAR] = clear_i;

  tmr_sync #(.WIDTH(N_SYNC), .DEPTH(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  assign start_rise = lvl[IX_START] & ~prev[IX_START];
  assign tb_fall    = ~lvl[IX_TBASE] & prev[IX_TBASE];
  assign clear_hold = lvl[IX_CLEAR] & prev[IX_CLEAR];
  assign ext_clear  = clear_hold & ~lvl[IX_START];

  tmr_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_rise_i(start_rise),
    .ext_clear_i (ext_clear),
    .tb_fall_i   (tb_fall),
    .oneshot_i   (oneshot_i),
    .at_turn_i   (at_turn),
    .cmd_o       (cmd),
    .running_o   (running_o),
    .done_o      (done_o)
  );

  tmr_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .q_o      (q),
    .at_turn_o(at_turn)
  );

  assign half_n_o = ~q[0];
  assign slow_n_o = ~q[MSB];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic clk,
  input logic rst_n,
  input logic half_n_o,
  input logic slow_n_o,
  input logic running_o,
  input logic done_o,
  input logic start_rise,
  input logic tb_fall,
  input logic ext_clear
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (half_n_o && slow_n_o));

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (!half_n_o && !slow_n_o && running_o));

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_fall && !start_rise && !ext_clear) |=> ($stable(half_n_o) && $stable(slow_n_o)));

  p_step_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tb_fall && !start_rise && !ext_clear) |=> (half_n_o != $past(half_n_o) || done_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!running_o && half_n_o && slow_n_o));

  p_clear_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clear |=> !running_o);
endmodule

bind longrange_timer tmr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_n_o  (half_n_o),
  .slow_n_o  (slow_n_o),
  .running_o (running_o),
  .done_o    (done_o),
  .start_rise(start_rise),
  .tb_fall   (tb_fall),
  .ext_clear (ext_clear)
);

// File: tb/longrange_timer_bench.sv
module longrange_timer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tbase = 1'b0, start = 1'b0, clr = 1'b0, oneshot = 1'b0;
  logic half_n, slow_n, running, done;

  longrange_timer u_longrange_timer (
    .clk(clk), .rst_n(rst_n), .tbase_i(tbase), .start_i(start),
    .clear_i(clr), .oneshot_i(oneshot), .half_n_o(half_n),
    .slow_n_o(slow_n), .running_o(running), .done_o(done)
  );

  int    vectors = 0, miscompares = 0, done_seen = 0;
  string req = "R1";
  bit    finished = 1'b0;

  // behavioural reference: inputs seen two and three edges ago
  int m_cnt = 0;
  bit m_run = 0, m_done = 0;
  bit tb_h[3], st_h[3], cl_h[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_done = 0;
      for (int i = 0; i < 3; i++) begin tb_h[i] = 0; st_h[i] = 0; cl_h[i] = 0; end
    end else begin
      bit s_up, t_down, c_act;
      s_up   = st_h[1] && !st_h[2];
      t_down = !tb_h[1] && tb_h[2];
      c_act  = cl_h[1] && cl_h[2] && !st_h[1];
      m_done = 0;
      if (s_up) begin
        m_cnt = 255; m_run = 1;
      end else if (c_act) begin
        m_cnt = 0; m_run = 0;
      end else if (m_run && t_down) begin
        if (oneshot && m_cnt == 128) begin
          m_cnt = 0; m_run = 0; m_done = 1;
        end else begin
          m_cnt = (m_cnt + 255) % 256;
        end
      end
      tb_h[2] = tb_h[1]; tb_h[1] = tb_h[0]; tb_h[0] = tbase;
      st_h[2] = st_h[1]; st_h[1] = st_h[0]; st_h[0] = start;
      cl_h[2] = cl_h[1]; cl_h[1] = cl_h[0]; cl_h[0] = clr;
    end
  end

  task automatic check(string r, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t {half_n,slow_n,running,done} actual=%b expected=%b", r, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(req, {half_n, slow_n, running, done},
            {~m_cnt[0], ~m_cnt[7], m_run, m_done});
      if (done === 1'b1) done_seen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tb_pulses(int n);
    repeat (n) begin
      tbase = 1'b1; tick(2);
      tbase = 1'b0; tick(2);
    end
  endtask

  task automatic fire();
    start = 1'b1; tick(3);
    start = 1'b0; tick(3);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    vectors++; miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    req = "R1";
    check("R1", {half_n, slow_n, running, done}, 4'b1100);

    req = "R10";
    tb_pulses(10);
    check("R10", {half_n, slow_n, running}, 3'b110);

    req = "R2";
    fire();
    check("R2", {slow_n, running}, 2'b01);

    req = "R4";
    tb_pulses(600);

    req = "R8";
    fire(); tb_pulses(50);
    fire();
    check("R8", {half_n, slow_n, running}, 3'b001);
    tb_pulses(20);

    req = "R6";
    clr = 1'b1; tick(6); clr = 1'b0; tick(2);
    check("R6", {half_n, slow_n, running}, 3'b110);
    start = 1'b1; tick(5);
    clr = 1'b1; tick(6);
    check("R6", {running}, 1'b1);
    start = 1'b0; tick(6);
    check("R6", {half_n, slow_n, running}, 3'b110);
    clr = 1'b0; tick(4);

    req = "R7";
    start = 1'b1; clr = 1'b1; tick(6);
    check("R7", {running}, 1'b1);
    start = 1'b0; tick(6); clr = 1'b0; tick(4);

    req = "R9";
    fire(); tb_pulses(3);
    tbase = 1'b1; tick(3);
    tbase = 1'b0; start = 1'b1; tick(4);
    check("R9", {half_n, slow_n, running}, 3'b001);
    start = 1'b0; tick(3);
    tb_pulses(5);

    req = "R3";
    tbase = 1'b1; tick(10);
    tb_pulses(9);

    req = "R5";
    clr = 1'b1; tick(6); clr = 1'b0; tick(3);
    oneshot = 1'b1; tick(2);
    done_seen = 0;
    fire(); tb_pulses(140);
    check("R5", {half_n, slow_n, running, 1'b0}, 4'b1100);
    check("R5", 4'(done_seen), 4'd1);
    done_seen = 0;
    fire(); tb_pulses(60); fire(); tb_pulses(200);
    check("R5", 4'(done_seen), 4'd1);
    tick(5);
    finish_run();
  end
endmodule